// File: doc/BRIEF.md
# Wired-to-Message Interrupt Generator

This block turns a bank of wired interrupt lines into message-signaled interrupt writes. Every pin owns a 22-bit vector (a 12-bit device ID and a 10-bit event ID) and a type bit that picks rising-edge or active-high level sensing. When a pin triggers it becomes pending. A round-robin arbiter picks one pending pin and loads its vector into a one-deep output register, which drives a valid/ready message port. The pin then stays in service until software writes a 1 to its bit in the clear window. The message target address is fixed outside the block, so each message carries only the two IDs.

Software reaches the block through a 32-bit register port with separate write and read strobes. Read data comes back on the cycle after the read strobe. There are three windows: the type words at offset 0x0000, the per-pin vectors at 0x0200 + 4*pin, and the clear/status words at 0xA000. Each type or clear word covers 32 pins, with pin p at word p/32, bit p%32.

Top module: `w2m_gen`

## Requirements
- R1: After reset, every type bit, vector and status bit is zero, msg_valid is 0 and reg_rdata is 0, so every pin defaults to rising-edge sensing with nothing pending.
- R2: A write to 0x0200 + 4*p stores wdata[21:0] as the vector of pin p, with the device ID in bits [11:0] and the event ID in bits [21:12]. A read of that address returns the vector with bits [31:22] as zero.
- R3: A write to 0x0000 + 4*w stores type bits for pins 32*w to 32*w+31, pin p at bit p%32, and a read returns them. A type bit of 1 selects active-high level sensing and 0 selects rising-edge sensing.
- R4: A rising-edge pin becomes pending on a 0-to-1 transition of its input sampled on consecutive clocks. Holding the input high afterwards produces no further messages.
- R5: A level pin becomes pending whenever its input is high and it is neither pending nor in service. If its input is still high after a clear, it triggers again.
- R6: Each pending pin produces exactly one message. When its vector is loaded into the output register it leaves pending and enters service, and triggers are ignored until it is cleared.
- R7: Writing a 1 to bit p%32 of word 0xA000 + 4*(p/32) returns pin p to idle, and this wins over a trigger in the same cycle. Writing 0 bits has no effect. A read of a clear word returns 1 for each pin that is pending or in service.
- R8: When several pins are pending, the next message goes to the first pending pin after the last one served, in ascending order with wraparound. After reset the scan starts at pin 0.
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_dev_id and msg_event_id stay unchanged. A new message can load on the same cycle that a handshake completes.
- R10: Writes to addresses outside the three windows change no state, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | Wired interrupt inputs, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the sink |
| msg_dev_id | output | 12 | Device ID of the current message |
| msg_event_id | output | 10 | Event ID of the current message |

## Verification
The assertions check on every cycle the properties that depend only on local state. A held message stays stable under backpressure. A pin is never pending and in service at once. A clear always lands on the next cycle, a loaded pin enters service, and the arbiter grants one requester at most and only one that is asking.

Some behaviours can only be shown by the bench's scenarios and its cycle-by-cycle reference model. These are the round-robin order across a burst of pins, the difference between held edge inputs and held level inputs after a clear, the readback layout of vectors and status, and the absence of side effects from writes of zero bits or writes to unmapped addresses.

// File: rtl/w2m_pkg.sv
package w2m_pkg;
  localparam int DEV_W = 12;
  localparam int EVT_W = 10;
  localparam int VEC_W = DEV_W + EVT_W;
  // window base offsets within the node
  localparam int TYPE_BASE = 'h0000;
  localparam int VEC_BASE  = 'h0200;
  localparam int CLR_BASE  = 'hA000;

  // packed so that evt sits in [21:12] and dev in [11:0]
  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [DEV_W-1:0] dev;
  } vec_t;
endpackage

// File: rtl/w2m_regs.sv
module w2m_regs
  import w2m_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int ADDR_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic [NUM_PINS-1:0]        status,
  output logic [31:0]                reg_rdata,
  output logic [NUM_PINS-1:0]        type_bits,
  output vec_t [NUM_PINS-1:0]        vectors,
  output logic [NUM_PINS-1:0]        clr_mask
);
  localparam int WORDS  = NUM_PINS / 32;
  localparam int PIN_W  = $clog2(NUM_PINS);
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] TYPE_LO = ADDR_W'(TYPE_BASE);
  localparam logic [ADDR_W-1:0] TYPE_HI = ADDR_W'(TYPE_BASE + WORDS * 4);
  localparam logic [ADDR_W-1:0] VEC_LO  = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] VEC_HI  = ADDR_W'(VEC_BASE + NUM_PINS * 4);
  localparam logic [ADDR_W-1:0] CLR_LO  = ADDR_W'(CLR_BASE);
  localparam logic [ADDR_W-1:0] CLR_HI  = ADDR_W'(CLR_BASE + WORDS * 4);

  logic                type_hit, vec_hit, clr_hit;
  logic [ADDR_W-1:0]   type_off, vec_off, clr_off;
  logic [WORD_W-1:0]   type_word, clr_word;
  logic [PIN_W-1:0]    sel_pin;
  logic [NUM_PINS-1:0] type_q, type_d;
  vec_t [NUM_PINS-1:0] vec_q;
  logic                vec_we;
  logic [31:0]         rdata_q, rdata_d;

  // address decode
  always_comb begin
    type_off  = reg_addr - TYPE_LO;
    vec_off   = reg_addr - VEC_LO;
    clr_off   = reg_addr - CLR_LO;
    type_hit  = (reg_addr >= TYPE_LO) && (reg_addr < TYPE_HI);
    vec_hit   = (reg_addr >= VEC_LO)  && (reg_addr < VEC_HI);
    clr_hit   = (reg_addr >= CLR_LO)  && (reg_addr < CLR_HI);
    type_word = WORD_W'(type_off >> 2);
    clr_word  = WORD_W'(clr_off >> 2);
    sel_pin   = PIN_W'(vec_off >> 2);
  end

  // type bits: next state
  always_comb begin
    type_d = type_q;
    if (reg_wr && type_hit) type_d[{type_word, 5'd0} +: 32] = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_q <= '0;
    else        type_q <= type_d;
  end

  assign vec_we = reg_wr && vec_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_we) vec_q[sel_pin] <= vec_t'(reg_wdata[VEC_W-1:0]);
  end

  // write-one clear pulse
  always_comb begin
    clr_mask = '0;
    if (reg_wr && clr_hit) clr_mask[{clr_word, 5'd0} +: 32] = reg_wdata;
  end

  // read mux
  always_comb begin
    rdata_d = '0;
    if (type_hit)     rdata_d = type_q[{type_word, 5'd0} +: 32];
    else if (vec_hit) rdata_d = {{(32-VEC_W){1'b0}}, vec_q[sel_pin]};
    else if (clr_hit) rdata_d = status[{clr_word, 5'd0} +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign type_bits = type_q;
  assign vectors   = vec_q;

  // R2: a vector write lands in the addressed pin on the next cycle
  a_r2_vec_store: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> (vec_q[$past(sel_pin)] == vec_t'($past(reg_wdata[VEC_W-1:0]))));

  // R10: an access outside every window reads back zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !type_hit && !vec_hit && !clr_hit) |=> (reg_rdata == 32'd0));
endmodule

// File: rtl/w2m_pin_state.sv
module w2m_pin_state #(
  parameter int NUM_PINS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] type_bits,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] take,
  output logic [NUM_PINS-1:0] pend,
  output logic [NUM_PINS-1:0] insvc
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic irq_q, pend_q, insvc_q;
    logic trig, pend_d, insvc_d;

    // level pins trigger while high, edge pins on a 0-to-1 step
    always_comb begin
      trig    = type_bits[p] ? irq_in[p] : (irq_in[p] & ~irq_q);
      pend_d  = pend_q;
      insvc_d = insvc_q;
      if (clr_mask[p]) begin
        pend_d  = 1'b0;
        insvc_d = 1'b0;
      end else if (take[p]) begin
        pend_d  = 1'b0;
        insvc_d = 1'b1;
      end else if (trig && !pend_q && !insvc_q) begin
        pend_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q   <= 1'b0;
        pend_q  <= 1'b0;
        insvc_q <= 1'b0;
      end else begin
        irq_q   <= irq_in[p];
        pend_q  <= pend_d;
        insvc_q <= insvc_d;
      end
    end

    assign pend[p]  = pend_q;
    assign insvc[p] = insvc_q;

    // R6: a pin is never pending and in service at once
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q && insvc_q));
    // R6: a pin whose vector was loaded enters service
    a_r6_take_enters_svc: assert property (@(posedge clk) disable iff (!rst_n)
      (take[p] && !clr_mask[p]) |=> insvc_q);
    // R7: a clear returns the pin to idle on the next cycle
    a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[p] |=> (!pend_q && !insvc_q));
  end
endmodule

// File: rtl/w2m_rr_arb.sv
module w2m_rr_arb #(
  parameter int NUM_PINS = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         req,
  input  logic                        adv,
  output logic                        gnt_vld,
  output logic [$clog2(NUM_PINS)-1:0] gnt_idx,
  output logic [NUM_PINS-1:0]         gnt_oh
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  // scan upward from the pin after the last one served
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = ptr_q;
    for (int i = 1; i <= NUM_PINS; i++) begin
      int cand;
      cand = int'(ptr_q) + i;
      if (cand >= NUM_PINS) cand = cand - NUM_PINS;
      if (!gnt_vld && req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDX_W'(cand);
      end
    end
    gnt_oh = '0;
    if (gnt_vld) gnt_oh[gnt_idx] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && gnt_vld) ptr_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IDX_W'(NUM_PINS - 1);
    else        ptr_q <= ptr_d;
  end

  // R8: at most one grant, and only to a requester
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh));
  a_r8_gnt_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_oh & ~req) == '0));
endmodule

// File: rtl/w2m_gen.sv
module w2m_gen
  import w2m_pkg::*;
#(
  parameter int NUM_PINS = 128,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [DEV_W-1:0]    msg_dev_id,
  output logic [EVT_W-1:0]    msg_event_id
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic                rst_meta_q, rst_sync_q;
  logic [NUM_PINS-1:0] type_bits, clr_mask, pend, insvc, take, gnt_oh;
  vec_t [NUM_PINS-1:0] vectors;
  logic                gnt_vld, load;
  logic [IDX_W-1:0]    gnt_idx;
  logic                valid_q, valid_d;
  vec_t                msg_q, msg_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  w2m_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(pend | insvc), .reg_rdata(reg_rdata),
    .type_bits(type_bits), .vectors(vectors), .clr_mask(clr_mask)
  );

  w2m_pin_state #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk(clk), .rst_n(rst_sync_q),
    .irq_in(irq_in), .type_bits(type_bits), .clr_mask(clr_mask),
    .take(take), .pend(pend), .insvc(insvc)
  );

  w2m_rr_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst_n(rst_sync_q),
    .req(pend), .adv(load),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx), .gnt_oh(gnt_oh)
  );

  // one-deep output register: reload when empty or draining
  always_comb begin
    load    = gnt_vld && (!valid_q || msg_ready);
    take    = load ? gnt_oh : '0;
    valid_d = load || (valid_q && !msg_ready);
    msg_d   = load ? vectors[gnt_idx] : msg_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      msg_q   <= msg_d;
    end
  end

  assign msg_valid    = valid_q;
  assign msg_dev_id   = msg_q.dev;
  assign msg_event_id = msg_q.evt;

  // R9: a stalled message holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_dev_id) && $stable(msg_event_id)));
  // R1: nothing is offered right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_sync_q) |-> !msg_valid);
endmodule

// File: tb/w2m_gen_bench.sv
module w2m_gen_bench;
  localparam int NP = 128;
  localparam int W  = NP / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] irq_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid, msg_ready = 1'b1;
  logic [11:0]   msg_dev_id;
  logic [9:0]    msg_event_id;

  always #5 clk = ~clk;

  w2m_gen u_w2m_gen (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dev_id(msg_dev_id), .msg_event_id(msg_event_id)
  );

  int checks = 0, errors = 0, cyc = 0, hs_count = 0;
  string cur_tag = "R1";
  logic [11:0] hs_q[$];

  // behavioural reference state
  bit [NP-1:0] m_type, m_pend, m_insvc, m_irq_q;
  logic [21:0] m_vec [NP];
  bit          m_valid;
  logic [21:0] m_msg;
  logic [31:0] m_rdata;
  int          m_ptr;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [15:0] a);
    if (a < 16'(W*4))                          return m_type[(a>>2)*32 +: 32];
    if (a >= 16'h0200 && a < 16'(16'h0200 + NP*4)) return {10'd0, m_vec[(a-16'h0200)>>2]};
    if (a >= 16'hA000 && a < 16'(16'hA000 + W*4))  return (m_pend | m_insvc) >> (((a-16'hA000)>>2)*32);
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_type = '0; m_pend = '0; m_insvc = '0; m_irq_q = '0;
      foreach (m_vec[i]) m_vec[i] = '0;
      m_valid = 0; m_msg = '0; m_rdata = '0; m_ptr = NP - 1;
    end else begin
      int win;
      bit ld, trig;
      bit [NP-1:0] clr;
      win = -1;
      for (int i = 1; i <= NP; i++) begin
        int c;
        c = (m_ptr + i) % NP;
        if (win < 0 && m_pend[c]) win = c;
      end
      ld = (win >= 0) && (!m_valid || msg_ready);
      if (reg_rd) m_rdata = mread(reg_addr);
      clr = '0;
      if (reg_wr && reg_addr >= 16'hA000 && reg_addr < 16'(16'hA000 + W*4))
        clr[((reg_addr-16'hA000)>>2)*32 +: 32] = reg_wdata;
      for (int p = 0; p < NP; p++) begin
        trig = m_type[p] ? irq_in[p] : (irq_in[p] && !m_irq_q[p]);
        if (clr[p]) begin m_pend[p] = 0; m_insvc[p] = 0; end
        else if (ld && win == p) begin m_pend[p] = 0; m_insvc[p] = 1; end
        else if (trig && !m_pend[p] && !m_insvc[p]) m_pend[p] = 1;
        m_irq_q[p] = irq_in[p];
      end
      if (ld) begin m_valid = 1; m_msg = m_vec[win]; m_ptr = win; end
      else if (msg_ready) m_valid = 0;
      if (reg_wr && reg_addr < 16'(W*4)) m_type[(reg_addr>>2)*32 +: 32] = reg_wdata;
      if (reg_wr && reg_addr >= 16'h0200 && reg_addr < 16'(16'h0200 + NP*4))
        m_vec[(reg_addr-16'h0200)>>2] = reg_wdata[21:0];
    end
  end

  // handshake log, independent of the model
  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      hs_count++;
      hs_q.push_back(msg_dev_id);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("msg_valid", 32'(msg_valid), 32'(m_valid));
      if (m_valid) begin
        chk("msg_dev_id", 32'(msg_dev_id), 32'(m_msg[11:0]));
        chk("msg_event_id", 32'(msg_event_id), 32'(m_msg[21:12]));
      end
      chk("reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_chk(logic [15:0] a, logic [31:0] exp, string what);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    chk(what, reg_rdata, exp);
  endtask

  function automatic logic [21:0] vec_of(int p);
    return {10'(p * 7 + 3), 12'(12'h100 + p)};
  endfunction

  initial begin
    int base;
    tick(3);
    rst_n = 1;
    tick(4);
    // R1 reset state
    cur_tag = "R1";
    chk("R1 msg_valid after reset", 32'(msg_valid), 32'd0);
    chk("R1 rdata after reset", reg_rdata, 32'd0);
    rd_chk(16'h0000, 32'd0, "R1 type word0");
    rd_chk(16'h0200, 32'd0, "R1 vector pin0");
    rd_chk(16'hA00C, 32'd0, "R1 status word3");

    // R2 vectors, upper bits forced high on write
    cur_tag = "R2";
    for (int p = 0; p < NP; p++) wr(16'(16'h0200 + p*4), 32'hFFC0_0000 | 32'(vec_of(p)));
    rd_chk(16'h0200 + 16'd20, 32'(vec_of(5)), "R2 vector pin5 readback");
    rd_chk(16'h0200 + 16'(127*4), 32'(vec_of(127)), "R2 vector pin127 readback");

    // R3 type bits: pins 33,34 and 100 level
    cur_tag = "R3";
    wr(16'h0004, 32'h0000_0006);
    wr(16'h000C, 32'h0000_0010);
    rd_chk(16'h0004, 32'h6, "R3 type word1 readback");
    rd_chk(16'h000C, 32'h10, "R3 type word3 readback");

    // R4 edge pin 5
    cur_tag = "R4";
    base = hs_count;
    irq_in[5] = 1;
    tick(10);
    chk("R4 one message on rise", 32'(hs_count - base), 32'd1);
    chk("R4 dev id of pin5", 32'(hs_q[$]), 32'(vec_of(5) & 22'hFFF));
    cur_tag = "R6";
    tick(10);
    chk("R6 no repeat while in service", 32'(hs_count - base), 32'd1);
    rd_chk(16'hA000, 32'h20, "R6 pin5 in service status");
    cur_tag = "R7";
    wr(16'hA000, 32'h20);
    tick(10);
    chk("R7 held edge input no retrigger", 32'(hs_count - base), 32'd1);
    rd_chk(16'hA000, 32'h0, "R7 pin5 idle after clear");
    irq_in[5] = 0; tick(2); irq_in[5] = 1; tick(10);
    chk("R4 second rise second message", 32'(hs_count - base), 32'd2);
    wr(16'hA000, 32'h20); irq_in[5] = 0; tick(2);

    // R5 level pin 33
    cur_tag = "R5";
    base = hs_count;
    irq_in[33] = 1;
    tick(10);
    chk("R5 level message", 32'(hs_count - base), 32'd1);
    cur_tag = "R7";
    wr(16'hA004, 32'h0);
    tick(5);
    rd_chk(16'hA004, 32'h2, "R7 zero write leaves status");
    chk("R7 zero write no message", 32'(hs_count - base), 32'd1);
    cur_tag = "R5";
    wr(16'hA004, 32'h2);
    tick(10);
    chk("R5 level retrigger after clear", 32'(hs_count - base), 32'd2);
    irq_in[33] = 0;
    wr(16'hA004, 32'h2);
    tick(5);
    rd_chk(16'hA004, 32'h0, "R5 level idle after drop and clear");

    // R8 / R9 burst with backpressure
    cur_tag = "R9";
    msg_ready = 0;
    hs_q.delete();
    irq_in[3] = 1; irq_in[7] = 1; irq_in[64] = 1; irq_in[120] = 1;
    tick(12);
    chk("R9 valid held under stall", 32'(msg_valid), 32'd1);
    chk("R9 no handshake under stall", 32'(hs_q.size()), 32'd0);
    cur_tag = "R8";
    msg_ready = 1;
    tick(10);
    chk("R8 burst count", 32'(hs_q.size()), 32'd4);
    if (hs_q.size() == 4) begin
      chk("R8 order 1st", 32'(hs_q[0]), 32'h100 + 64);
      chk("R8 order 2nd", 32'(hs_q[1]), 32'h100 + 120);
      chk("R8 order 3rd", 32'(hs_q[2]), 32'h100 + 3);
      chk("R8 order 4th", 32'(hs_q[3]), 32'h100 + 7);
    end
    for (int w = 0; w < W; w++) wr(16'(16'hA000 + w*4), 32'hFFFF_FFFF);
    irq_in = '0;
    tick(3);

    // R10 unmapped addresses
    cur_tag = "R10";
    base = hs_count;
    wr(16'h0010, 32'hFFFF_FFFF);
    wr(16'h0400, 32'hFFFF_FFFF);
    wr(16'hA010, 32'hFFFF_FFFF);
    wr(16'h5000, 32'hFFFF_FFFF);
    tick(3);
    rd_chk(16'h0010, 32'h0, "R10 read past type window");
    rd_chk(16'h0400, 32'h0, "R10 read past vector window");
    rd_chk(16'h0000, 32'h0, "R10 type word0 untouched");
    rd_chk(16'h000C, 32'h10, "R10 type word3 untouched");
    rd_chk(16'h0200 + 16'(127*4), 32'(vec_of(127)), "R10 vector pin127 untouched");
    chk("R10 no message", 32'(hs_count - base), 32'd0);

    summary();
    $finish;
  end
endmodule